// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a four-bank DDR SDRAM from power-on to a usable state. After the system reports that supplies, reference and clock are settled, it holds the clock-enable low and keeps the chip deselected for a programmable microsecond interval. It then drives a fixed chain of commands on the command, bank and address pins: a NOP with clock-enable raised, precharge of every bank, an extended mode-register write that turns the DLL on, a base mode-register write that resets the DLL, a second full precharge, two auto-refresh commands, and a final base mode-register write with the DLL-reset bit cleared.

Every command is followed by a parameterized run of NOP cycles, which covers the minimum spacing between commands. When the last write has settled, `init_done` rises and the normal access logic takes over the pins. A separate flag, `rd_ok`, stays low until the DLL has had its lock window after the reset write.

A `restart` input reissues the command chain at any time after the initial wait. It skips the power-up delay, keeps clock-enable high, and never writes the memory array.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until a `stable` pulse is sampled, `cke` is 0, `cs_n` is 1, and `init_done` and `rd_ok` are 0. A `restart` pulse in this state has no effect.
- R2: After `stable` is sampled, `cke` stays 0 with `cs_n` 1 for exactly CLK_MHZ*WAIT_US cycles. In the next cycle `cke` goes to 1 and a NOP is driven. While `cke` is 0, `cs_n` is always 1.
- R3: Command codes as {cs_n,ras_n,cas_n,we_n}: NOP 0111, precharge 0010, auto refresh 0001, mode-register write 0000. After the NOP, the non-NOP commands appear in this order: precharge, extended write, DLL-reset write, precharge, refresh, refresh, final write.
- R4: Each step, including the opening NOP step, lasts GAP+1 cycles: one command cycle followed by GAP NOP cycles. Command k (k=1..7) therefore appears GAP+1 cycles after command k-1, and the first precharge appears GAP+1 cycles after `cke` rises.
- R5: Every precharge drives `addr[10]`=1, which selects all banks.
- R6: The extended write drives `ba`=01 and `addr` = `emr_val` with bit 0 forced to 0, which enables the DLL.
- R7: Both base writes drive `ba`=00. The first drives `addr` = `mr_val` with bit 8 (DLL reset) forced to 1. The final one drives `mr_val` with bit 8 forced to 0.
- R8: `init_done` first goes high GAP+1 cycles after the final write and then stays high until reset or restart.
- R9: `rd_ok` is high only while `init_done` is high. It first rises exactly LOCK cycles after the DLL-reset write cycle, or with `init_done` if that comes later.
- R10: A `restart` sampled after the wait has ended makes the next cycle the opening NOP step, with `cke` 1 and `init_done` and `rd_ok` 0. This holds even when `restart` coincides with the final write. A `restart` during the wait has no effect.
- R11: A `stable` pulse after the wait has ended has no effect: no command is driven and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| stable | input | 1 | Pulse: supplies, reference and clock are settled |
| restart | input | 1 | Pulse: reissue the command chain |
| mr_val | input | AW | Operating parameters for the base mode register |
| emr_val | input | AW | Value for the extended mode register |
| cke | output | 1 | Clock enable to the SDRAM |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | AW | Address bus |
| init_done | output | 1 | Initialization complete |
| rd_ok | output | 1 | Reads permitted (DLL lock window met) |

## Verification
Two actions can land in the same cycle: the step advance that completes the final mode-register write, and a `restart` request. The bench waits for the final write to appear on the pins and asserts `restart` in that exact cycle. It then checks three things: `init_done` never rises, the command chain starts again from the NOP step at freshly computed cycles, and `rd_ok` waits for the new DLL-reset write. A second pairing is a `restart` arriving during the power-up wait. For that case the bench checks that the clock-enable rise is not moved.

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq #(
  parameter int unsigned CLK_MHZ = 250,
  parameter int unsigned WAIT_US = 200,
  parameter int unsigned GAP     = 2,
  parameter int unsigned LOCK    = 200,
  parameter int unsigned AW      = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stable,
  input  logic          restart,
  input  logic [AW-1:0] mr_val,
  input  logic [AW-1:0] emr_val,
  output logic          cke,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic [1:0]    ba,
  output logic [AW-1:0] addr,
  output logic          init_done,
  output logic          rd_ok
);
  localparam int unsigned WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int unsigned WW = $clog2(WAIT_CYC + 1);
  localparam int unsigned GW = (GAP < 1) ? 1 : $clog2(GAP + 1);
  localparam int unsigned LW = $clog2(LOCK + 1);
  localparam logic [AW-1:0] DLL_RST = AW'(1) << 8;
  localparam logic [AW-1:0] DLL_OFF = AW'(1);
  localparam logic [AW-1:0] ALL_BK  = AW'(1) << 10;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT, ST_NOP, ST_PRE1, ST_EMR, ST_MRR,
    ST_PRE2, ST_REF1, ST_REF2, ST_MRF, ST_DONE
  } st_t;

  st_t           st;
  logic [WW-1:0] wcnt;
  logic [GW-1:0] gcnt;
  logic [LW-1:0] lcnt;
  logic [3:0]    cmd;

  wire issue    = (gcnt == '0);
  wire step_end = (gcnt == GW'(GAP));
  wire lock_met = (lcnt == LW'(LOCK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      wcnt <= '0;
      gcnt <= '0;
      lcnt <= '0;
    end else begin
      if (lcnt != '0 && !lock_met) lcnt <= lcnt + 1'b1;
      case (st)
        ST_IDLE: if (stable) begin
          st   <= ST_WAIT;
          wcnt <= '0;
        end
        ST_WAIT: if (wcnt == WW'(WAIT_CYC - 1)) begin
          st   <= ST_NOP;
          gcnt <= '0;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
        default: if (restart) begin
          st   <= ST_NOP;
          gcnt <= '0;
          lcnt <= '0;
        end else if (st != ST_DONE) begin
          if (st == ST_MRR && issue) lcnt <= LW'(1);
          if (step_end) begin
            gcnt <= '0;
            st   <= st_t'(st + 4'd1);
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign cke       = (st != ST_IDLE) && (st != ST_WAIT);
  assign init_done = (st == ST_DONE);
  assign rd_ok     = init_done && lock_met;

  always_comb begin
    cmd  = cke ? 4'b0111 : 4'b1111;
    ba   = 2'b00;
    addr = '0;
    if (issue) begin
      case (st)
        ST_PRE1, ST_PRE2: begin
          cmd  = 4'b0010;
          addr = ALL_BK;
        end
        ST_EMR: begin
          cmd  = 4'b0000;
          ba   = 2'b01;
          addr = emr_val & ~DLL_OFF;
        end
        ST_MRR: begin
          cmd  = 4'b0000;
          addr = mr_val | DLL_RST;
        end
        ST_REF1, ST_REF2: cmd = 4'b0001;
        ST_MRF: begin
          cmd  = 4'b0000;
          addr = mr_val & ~DLL_RST;
        end
        default: ;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
endmodule

module ddr_pwrup_seq_chk #(
  parameter int unsigned GAP  = 2,
  parameter int unsigned LOCK = 200,
  parameter int unsigned AW   = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke,
  input logic          cs_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic [1:0]    ba,
  input logic [AW-1:0] addr,
  input logic          init_done,
  input logic          rd_ok
);
  wire is_cmd = !cs_n && ({ras_n, cas_n, we_n} != 3'b111);
  wire is_mrs = !cs_n && !ras_n && !cas_n && !we_n;
  wire is_pre = !cs_n && !ras_n && cas_n && !we_n;

  int unsigned since;
  int unsigned lk;
  logic        last_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since    <= GAP;
      lk       <= 0;
      last_clr <= 1'b0;
    end else begin
      if (is_cmd) since <= 0;
      else if (since < GAP) since <= since + 1;
      if (is_mrs && ba == 2'b00 && addr[8]) lk <= 1;
      else if (lk != 0 && lk < LOCK) lk <= lk + 1;
      if (is_cmd) last_clr <= is_mrs && ba == 2'b00 && !addr[8];
    end
  end

  AST_DESEL_WHILE_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !cke |-> cs_n); // R2
  AST_CMD_SPACING: assert property (@(posedge clk) disable iff (!rst_n) is_cmd |-> since == GAP); // R4
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n) is_pre |-> addr[10]); // R5
  AST_EMR_DLL_ON: assert property (@(posedge clk) disable iff (!rst_n) (is_mrs && ba == 2'b01) |-> !addr[0]); // R6
  AST_DONE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) $rose(init_done) |-> last_clr); // R8
  AST_RD_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) rd_ok |-> init_done); // R9
  AST_RD_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n) rd_ok |-> lk >= LOCK); // R9
endmodule

bind ddr_pwrup_seq ddr_pwrup_seq_chk #(.GAP(GAP), .LOCK(LOCK), .AW(AW)) u_chk (.*);

// File: tb/test_ddr_pwrup_seq.sv
module test_ddr_pwrup_seq;
  localparam int CLK_MHZ = 250;
  localparam int WAIT_US = 1;
  localparam int GAP = 2;
  localparam int LOCK = 200;
  localparam int W = CLK_MHZ * WAIT_US;
  localparam int S = GAP + 1;

  logic clk = 0;
  logic rst_n = 0;
  logic stable = 0;
  logic restart = 0;
  logic [11:0] mr_val = '0;
  logic [11:0] emr_val = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done, rd_ok;
  logic [1:0] ba;
  logic [11:0] addr;

  always #2 clk = ~clk;

  ddr_pwrup_seq #(.CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .GAP(GAP), .LOCK(LOCK), .AW(12)) i_ddr_pwrup_seq (
    .clk(clk), .rst_n(rst_n), .stable(stable), .restart(restart),
    .mr_val(mr_val), .emr_val(emr_val), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .init_done(init_done), .rd_ok(rd_ok));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [3:0]  lg_cmd [0:31];
  logic [1:0]  lg_ba  [0:31];
  logic [11:0] lg_addr[0:31];
  int          lg_cyc [0:31];
  int lg_n = 0;
  int cke_rise = -1, done_rise = -1, rd_rise = -1;
  logic cke_q = 0, done_q = 0, rd_q = 0;

  always @(negedge clk) begin
    if (cke && !cke_q) cke_rise = cyc;
    if (init_done && !done_q) done_rise = cyc;
    if (rd_ok && !rd_q) rd_rise = cyc;
    cke_q = cke; done_q = init_done; rd_q = rd_ok;
    if (!cs_n && {ras_n, cas_n, we_n} != 3'b111 && lg_n < 32) begin
      lg_cmd[lg_n] = {cs_n, ras_n, cas_n, we_n};
      lg_ba[lg_n] = ba;
      lg_addr[lg_n] = addr;
      lg_cyc[lg_n] = cyc;
      lg_n = lg_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    lg_n = 0; cke_rise = -1; done_rise = -1; rd_rise = -1;
  endtask

  task automatic check_chain(input int c0, input logic [11:0] mv, input logic [11:0] ev, input string tag);
    logic [3:0] ec [0:6];
    ec[0] = 4'b0010; ec[1] = 4'b0000; ec[2] = 4'b0000; ec[3] = 4'b0010;
    ec[4] = 4'b0001; ec[5] = 4'b0001; ec[6] = 4'b0000;
    chk(lg_n == 7, {"R3 command count ", tag}, lg_n, 7);
    for (int i = 0; i < 7; i++) begin
      chk(lg_cmd[i] == ec[i], {"R3 command order ", tag}, lg_cmd[i], ec[i]);
      chk(lg_cyc[i] == c0 + (i + 1) * S, {"R4 command cycle ", tag}, lg_cyc[i], c0 + (i + 1) * S);
    end
    chk(lg_addr[0][10] && lg_addr[3][10], {"R5 precharge all ", tag}, {lg_addr[0][10], lg_addr[3][10]}, 3);
    chk(lg_ba[1] == 2'b01, {"R6 extended bank ", tag}, lg_ba[1], 1);
    chk(lg_addr[1] == (ev & 12'hFFE), {"R6 extended value ", tag}, lg_addr[1], ev & 12'hFFE);
    chk(lg_ba[2] == 0 && lg_addr[2] == (mv | 12'h100), {"R7 DLL reset write ", tag}, lg_addr[2], mv | 12'h100);
    chk(lg_ba[6] == 0 && lg_addr[6] == (mv & 12'hEFF), {"R7 final write ", tag}, lg_addr[6], mv & 12'hEFF);
    chk(done_rise == c0 + 8 * S, {"R8 done cycle ", tag}, done_rise, c0 + 8 * S);
    chk(rd_rise == c0 + 3 * S + LOCK, {"R9 read permit cycle ", tag}, rd_rise, c0 + 3 * S + LOCK);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!cke && cs_n && !init_done && !rd_ok, "R1 reset outputs", {cke, cs_n, init_done, rd_ok}, 4'b0100);
    rst_n = 1;
    repeat (5) @(negedge clk);
    restart = 1;
    @(negedge clk);
    restart = 0;
    repeat (30) @(negedge clk);
    chk(!cke && cs_n && !init_done, "R1 idle ignores restart", {cke, cs_n, init_done}, 3'b010);
  endtask

  task automatic t_full();
    int k;
    emr_val = 12'hFFF; mr_val = 12'h0A3;
    clear_log();
    @(negedge clk);
    stable = 1; k = cyc;
    @(negedge clk);
    stable = 0;
    repeat (20) @(negedge clk);
    restart = 1;
    @(negedge clk);
    restart = 0;
    while (!rd_ok) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(cke_rise == k + 1 + W, "R2 wait length, R10 restart ignored in wait", cke_rise, k + 1 + W);
    check_chain(cke_rise, 12'h0A3, 12'hFFF, "full");
  endtask

  task automatic t_stable_late();
    clear_log();
    stable = 1;
    @(negedge clk);
    stable = 0;
    repeat (30) @(negedge clk);
    chk(lg_n == 0, "R11 no command after late strobe", lg_n, 0);
    chk(init_done && rd_ok, "R11 flags kept", {init_done, rd_ok}, 3);
  endtask

  task automatic t_restart_done();
    restart = 1;
    @(negedge clk);
    restart = 0;
    chk(cke && !init_done && !rd_ok && !cs_n, "R10 restart after done", {cke, init_done, rd_ok, cs_n}, 4'b1000);
    while (!rd_ok) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_collision();
    int c;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    emr_val = 12'h000; mr_val = 12'h1FF;
    @(negedge clk);
    stable = 1;
    @(negedge clk);
    stable = 0;
    while (!(!cs_n && !ras_n && !cas_n && !we_n && ba == 2'b00 && !addr[8])) @(negedge clk);
    c = cyc;
    restart = 1;
    @(negedge clk);
    restart = 0;
    chk(!init_done && cke && !cs_n && {ras_n, cas_n, we_n} == 3'b111, "R10 restart wins over final step",
        {init_done, cke}, 2'b01);
    clear_log();
    while (!rd_ok) @(negedge clk);
    repeat (3) @(negedge clk);
    check_chain(c + 1, 12'h1FF, 12'h000, "collision");
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_full();
    t_stable_late();
    t_restart_done();
    t_collision();
    summary();
    $finish;
  end
endmodule